// File: doc/BRIEF.md
# Configurable UART Receive Channel

This block turns an asynchronous serial line into received characters. A 16-bit format word selects how many data bits a character carries, whether a parity bit follows and of which sense, and how long the stop interval is. An external baud generator supplies a tick at sixteen times the bit rate, and the line arrives already synchronised to the clock. The channel finds the start bit, samples each bit near its centre, checks parity and the first stop bit, and places the result in a two-entry holding buffer.

Each stored entry is a 16-bit word holding the character, a parity-error flag and a framing-error flag. A break (the line held low through the stop position) shows up as a framing error with an all-zero character. The consumer pops the head entry with a strobe. A data-available output is high whenever the buffer holds anything. An overflow pulse marks each character that was dropped because the buffer was full. A pair of one-cycle strobes switches reception on and off.

Top module: `uart_rx_channel`

## Requirements
- R1: The character length is format bits [3:0] plus 3, for field values 2 to 6 (5 to 9 bits). Any other field value selects 8 bits. Bits arrive least significant first and land in word bits [8:0], with unused upper data bits reading 0.
- R2: Format bits [9:8] select parity: 00 none, 10 even, 11 odd, and 01 is treated as none. Word bit 14 is set when the received parity bit does not match the selected sense, and it is always 0 with parity off.
- R3: Format bits [13:12] select the stop interval: 00 half a bit, 01 one bit, 11 two bits. Only the first stop bit is sampled. Word bit 15 is set when that sample is low. With two stop bits the character is stored before the second stop bit ends.
- R4: A break, meaning a frame whose data bits and first stop bit are all low, is stored as the word 16'h8000 when parity is off.
- R5: Word bits [13:9] always read 0.
- R6: The buffer holds two words in arrival order. The data-available output is high exactly when it is not empty. A pop removes the head entry. A pop while empty has no effect.
- R7: A character that completes while the buffer is full and no pop is present is discarded. The overflow output pulses for one cycle, and the stored words are unchanged.
- R8: Reception is off after reset. The enable strobe turns it on and the disable strobe turns it off, and disable wins when both are present. While off, the line is ignored and buffered words are kept.
- R9: A start is accepted only if the line is still low 8 ticks after the low level was first seen. A shorter low pulse produces no character.
- R10: After reset the buffer is empty, the read word is 0 and overflow is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_line | input | 1 | Synchronised serial input, idle high |
| frame_cfg | input | 16 | Format word: length [3:0], parity [9:8], stop [13:12] |
| rx_enable | input | 1 | Strobe that turns reception on |
| rx_disable | input | 1 | Strobe that turns reception off |
| pop | input | 1 | Removes the head buffer entry |
| rx_word | output | 16 | Head entry: {framing err, parity err, 5'b0, data[8:0]} |
| data_avail | output | 1 | Buffer not empty |
| overflow | output | 1 | One-cycle pulse per dropped character |

## Verification
A table of frames covers every character length, including an out-of-range length code. It sends even and odd parity both with a correct parity bit and with a flipped one, and all three stop intervals. This separates length decoding, parity sense and stop handling from one another. Frames with a low stop bit, and one with an all-zero break, show that framing-error detection is independent of the data. A valid second stop bit checked for early delivery shows that only the first stop bit gates the store. Directed runs cover a short low glitch, reception while switched off, simultaneous enable and disable, a pop on an empty buffer, and a third character into a full buffer. These expose start-validation, gating and buffer-ordering faults.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
package uart_rx_pkg;

    localparam int DATA_W = 9;
    localparam int WORD_W = 16;
    localparam int LEN_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef enum logic [1:0] {
        PAR_NONE,
        PAR_EVEN,
        PAR_ODD
    } par_mode_e;

    typedef struct packed {
        logic [LEN_W-1:0] nbits;
        par_mode_e        par;
        logic             half_stop;
    } frame_fmt_t;

    typedef struct packed {
        logic              ferr;
        logic              perr;
        logic [DATA_W-1:0] data;
    } rx_char_t;

    function automatic frame_fmt_t decode_frame(
        input logic [3:0] len_f,
        input logic [1:0] par_f,
        input logic [1:0] stop_f
    );
        frame_fmt_t f;
        if (len_f >= 4'd2 && len_f <= 4'd6) f.nbits = len_f + 4'd3;
        else                                f.nbits = 4'd8;
        case (par_f)
            2'b10:   f.par = PAR_EVEN;
            2'b11:   f.par = PAR_ODD;
            default: f.par = PAR_NONE;
        endcase
        f.half_stop = (stop_f == 2'b00);
        return f;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input rx_char_t c);
        return {c.ferr, c.perr, 5'b0, c.data};
    endfunction

endpackage

// File: rtl/uart_rx_framer.sv
`timescale 1ns/1ps
module uart_rx_framer
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              tick,
    input  logic              rxd,
    input  frame_fmt_t        fmt_in,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word
);
    localparam int CNT_W = $clog2(OVS);
    localparam int BI_W  = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] MID_PT  = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_PT = CNT_W'(OVS - 1);
    localparam logic [CNT_W-1:0] HALF_PT = CNT_W'(OVS - 1 - OVS / 4);

    rx_state_e         st;
    logic [CNT_W-1:0]  cnt;
    logic [BI_W-1:0]   bidx;
    logic [DATA_W-1:0] shreg;
    logic              ones;
    logic              parbit;
    frame_fmt_t        fmt;
    logic              perr_now;
    logic [CNT_W-1:0]  stop_pt;

    always_comb begin
        case (fmt.par)
            PAR_EVEN: perr_now = ones ^ parbit;
            PAR_ODD:  perr_now = ~(ones ^ parbit);
            default:  perr_now = 1'b0;
        endcase
        stop_pt = fmt.half_stop ? HALF_PT : FULL_PT;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            bidx      <= '0;
            shreg     <= '0;
            ones      <= 1'b0;
            parbit    <= 1'b0;
            fmt       <= '0;
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (tick) begin
                case (st)
                    ST_IDLE: if (!rxd) begin
                        st  <= ST_START;
                        cnt <= '0;
                        fmt <= fmt_in;
                    end
                    ST_START: if (cnt == MID_PT) begin
                        cnt   <= '0;
                        bidx  <= '0;
                        shreg <= '0;
                        ones  <= 1'b0;
                        st    <= rxd ? ST_IDLE : ST_DATA;
                    end else cnt <= cnt + 1'b1;
                    ST_DATA: if (cnt == FULL_PT) begin
                        cnt         <= '0;
                        shreg[bidx] <= rxd;
                        ones        <= ones ^ rxd;
                        if (bidx == BI_W'(fmt.nbits - 4'd1))
                            st <= (fmt.par == PAR_NONE) ? ST_STOP : ST_PAR;
                        else
                            bidx <= bidx + 1'b1;
                    end else cnt <= cnt + 1'b1;
                    ST_PAR: if (cnt == FULL_PT) begin
                        cnt    <= '0;
                        parbit <= rxd;
                        st     <= ST_STOP;
                    end else cnt <= cnt + 1'b1;
                    ST_STOP: if (cnt == stop_pt) begin
                        cnt       <= '0;
                        st        <= ST_IDLE;
                        out_valid <= 1'b1;
                        out_word  <= pack_word('{ferr: ~rxd, perr: perr_now, data: shreg});
                    end else cnt <= cnt + 1'b1;
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_word[13:9] == 5'd0)); // R5

    AST_START_REJECT: assert property (@(posedge clk) disable iff (rst)
        (en && tick && st == ST_START && cnt == MID_PT && rxd) |=> (st == ST_IDLE)); // R9

endmodule

// File: rtl/uart_rx_holdbuf.sv
`timescale 1ns/1ps
module uart_rx_holdbuf #(
    parameter int DEPTH = 2,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         avail,
    output logic         ovf
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] count;
    logic          do_pop, do_push, full;

    assign full    = (count == CW'(DEPTH));
    assign do_pop  = pop && (count != '0);
    assign do_push = push && (!full || do_pop);
    assign head    = mem[rp];
    assign avail   = (count != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            ovf <= push && !do_push;
            if (do_push) begin
                mem[wp] <= din;
                wp      <= (wp == LAST) ? '0 : wp + 1'b1;
            end
            if (do_pop) rp <= (rp == LAST) ? '0 : rp + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    AST_OVF_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (full && ovf && $stable(rp))); // R7

    AST_LAST_POP: assert property (@(posedge clk) disable iff (rst)
        (pop && count == CW'(1) && !push) |=> !avail); // R6

    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
        (pop && !avail && !push) |=> (!avail && $stable(rp))); // R6

endmodule

// File: rtl/uart_rx_channel.sv
`timescale 1ns/1ps
module uart_rx_channel
    import uart_rx_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              rx_line,
    input  logic [15:0]       frame_cfg,
    input  logic              rx_enable,
    input  logic              rx_disable,
    input  logic              pop,
    output logic [WORD_W-1:0] rx_word,
    output logic              data_avail,
    output logic              overflow
);
    logic              rx_on;
    logic              frm_valid;
    logic [WORD_W-1:0] frm_word;
    frame_fmt_t        fmt;
    logic              unused_cfg;

    assign fmt        = decode_frame(frame_cfg[3:0], frame_cfg[9:8], frame_cfg[13:12]);
    assign unused_cfg = ^{frame_cfg[15:14], frame_cfg[11:10], frame_cfg[7:4]};

    always_ff @(posedge clk) begin
        if (rst)             rx_on <= 1'b0;
        else if (rx_disable) rx_on <= 1'b0;
        else if (rx_enable)  rx_on <= 1'b1;
    end

    uart_rx_framer #(.OVS(OVS)) u_framer (
        .clk      (clk),
        .rst      (rst),
        .en       (rx_on),
        .tick     (baud_tick),
        .rxd      (rx_line),
        .fmt_in   (fmt),
        .out_valid(frm_valid),
        .out_word (frm_word)
    );

    uart_rx_holdbuf #(.DEPTH(DEPTH), .W(WORD_W)) u_buf (
        .clk  (clk),
        .rst  (rst),
        .push (frm_valid),
        .din  (frm_word),
        .pop  (pop),
        .head (rx_word),
        .avail(data_avail),
        .ovf  (overflow)
    );

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
        (!rx_on) |=> !frm_valid); // R8

    AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (rst)
        rx_disable |=> !rx_on); // R8

endmodule

// File: tb/uart_rx_channel_test.sv
`timescale 1ns/1ps
module uart_rx_channel_test;

    localparam int TDIV = 4;

    typedef struct packed {
        logic [15:0] cfg;
        logic [8:0]  data;
        logic        flip;
        logic        stop;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{16'h1005, 9'h0A5, 1'b0, 1'b1, 16'h00A5},  // R1 8N1
        '{16'h1005, 9'h03C, 1'b0, 1'b0, 16'h803C},  // R3 bad stop
        '{16'h1204, 9'h055, 1'b0, 1'b1, 16'h0055},  // R2 7E1 good
        '{16'h1204, 9'h055, 1'b1, 1'b1, 16'h4055},  // R2 7E1 flipped
        '{16'h3302, 9'h013, 1'b0, 1'b1, 16'h0013},  // R3 5O2 good
        '{16'h3302, 9'h01F, 1'b1, 1'b1, 16'h401F},  // R2 5O2 flipped
        '{16'h0003, 9'h02A, 1'b0, 1'b1, 16'h002A},  // R3 6N half stop
        '{16'h1206, 9'h1C3, 1'b0, 1'b1, 16'h01C3},  // R1 9E1
        '{16'h1003, 9'h03F, 1'b0, 1'b1, 16'h003F},  // R1 6N1 upper zero
        '{16'h1005, 9'h000, 1'b0, 1'b0, 16'h8000},  // R4 break
        '{16'h100F, 9'h081, 1'b0, 1'b1, 16'h0081}   // R1 bad length code
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        baud_tick = 1'b0;
    logic        rx_line = 1'b1;
    logic [15:0] frame_cfg = 16'h1005;
    logic        rx_enable = 1'b0;
    logic        rx_disable = 1'b0;
    logic        pop = 1'b0;
    logic [15:0] rx_word;
    logic        data_avail;
    logic        overflow;

    int checks = 0;
    int errors = 0;
    int ovf_cnt = 0;
    int tdiv_cnt = 0;
    bit done = 1'b0;

    uart_rx_channel uut (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .rx_line(rx_line),
        .frame_cfg(frame_cfg), .rx_enable(rx_enable), .rx_disable(rx_disable),
        .pop(pop), .rx_word(rx_word), .data_avail(data_avail), .overflow(overflow)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        tdiv_cnt  <= (tdiv_cnt == TDIV - 1) ? 0 : tdiv_cnt + 1;
        baud_tick <= (tdiv_cnt == TDIV - 1);
        if (overflow) ovf_cnt <= ovf_cnt + 1;
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int nticks);
        rx_line = v;
        repeat (nticks * TDIV) @(negedge clk);
    endtask

    task automatic strobe_en(input logic e, input logic d);
        @(negedge clk);
        rx_enable = e; rx_disable = d;
        @(negedge clk);
        rx_enable = 1'b0; rx_disable = 1'b0;
    endtask

    task automatic do_pop();
        @(negedge clk);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    task automatic send(input logic [15:0] cfg, input logic [8:0] d,
                        input logic flip, input logic stp, input string tag);
        int len;
        logic pb;
        frame_cfg = cfg;
        len = (cfg[3:0] >= 2 && cfg[3:0] <= 6) ? int'(cfg[3:0]) + 3 : 8;
        pb = 1'b0;
        @(negedge clk);
        hold(1'b0, 16);
        for (int i = 0; i < len; i++) begin
            hold(d[i], 16);
            pb ^= d[i];
        end
        if (cfg[9]) begin
            if (cfg[8]) pb = ~pb;
            hold(pb ^ flip, 16);
        end
        if (cfg[13:12] == 2'b00) hold(stp, 8);
        else hold(stp, 16);
        if (cfg[13:12] == 2'b11) begin
            chk({tag, " R3 stored before second stop ends"}, {15'd0, data_avail}, 16'd1);
            hold(1'b1, 16);
        end
        hold(1'b1, 24);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 reset avail", {15'd0, data_avail}, 16'd0);
        chk("R10 reset word", rx_word, 16'h0000);
        chk("R10 reset overflow", {15'd0, overflow}, 16'd0);

        send(16'h1005, 9'h05A, 1'b0, 1'b1, "R8 off");
        chk("R8 off after reset ignores line", {15'd0, data_avail}, 16'd0);

        strobe_en(1'b1, 1'b0);

        for (int v = 0; v < NV; v++) begin
            send(VEC[v].cfg, VEC[v].data, VEC[v].flip, VEC[v].stop, $sformatf("vec%0d", v));
            chk($sformatf("vec%0d R6 avail", v), {15'd0, data_avail}, 16'd1);
            chk($sformatf("vec%0d R1/R2/R3/R4/R5 word", v), rx_word, VEC[v].exp);
            do_pop();
            chk($sformatf("vec%0d R6 empty after pop", v), {15'd0, data_avail}, 16'd0);
        end

        // R9: low glitch shorter than the start window
        frame_cfg = 16'h1005;
        @(negedge clk);
        hold(1'b0, 3);
        hold(1'b1, 40);
        chk("R9 glitch gives no char", {15'd0, data_avail}, 16'd0);

        // R6: pop while empty has no effect
        do_pop();
        send(16'h1005, 9'h0C3, 1'b0, 1'b1, "R6");
        chk("R6 word after empty pop", rx_word, 16'h00C3);
        do_pop();
        chk("R6 empty again", {15'd0, data_avail}, 16'd0);

        // R7: third character into a full buffer
        begin
            int ovf_before;
            ovf_before = ovf_cnt;
            send(16'h1005, 9'h011, 1'b0, 1'b1, "R7a");
            send(16'h1005, 9'h022, 1'b0, 1'b1, "R7b");
            chk("R7 no overflow at two", 16'(ovf_cnt - ovf_before), 16'd0);
            send(16'h1005, 9'h033, 1'b0, 1'b1, "R7c");
            chk("R7 one overflow pulse", 16'(ovf_cnt - ovf_before), 16'd1);
        end
        chk("R7 head kept", rx_word, 16'h0011);
        do_pop();
        chk("R7 second kept", rx_word, 16'h0022);
        do_pop();
        chk("R7 third dropped", {15'd0, data_avail}, 16'd0);

        // R8: disable keeps buffer, line ignored
        send(16'h1005, 9'h044, 1'b0, 1'b1, "R8 pre");
        strobe_en(1'b0, 1'b1);
        send(16'h1005, 9'h099, 1'b0, 1'b1, "R8 off");
        chk("R8 disabled keeps word", rx_word, 16'h0044);
        do_pop();
        chk("R8 disabled stored nothing", {15'd0, data_avail}, 16'd0);

        // R8: enable and disable together, disable wins
        strobe_en(1'b1, 1'b1);
        send(16'h1005, 9'h066, 1'b0, 1'b1, "R8 both");
        chk("R8 disable wins", {15'd0, data_avail}, 16'd0);

        strobe_en(1'b1, 1'b0);
        send(16'h1005, 9'h077, 1'b0, 1'b1, "R8 re-enable");
        chk("R8 re-enabled receives", rx_word, 16'h0077);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule